// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port memory and watches the enable and address of each port. When both ports are enabled on the same address, it works out which port got there first. It then drives an active-low busy flag to the port that came second, and the earlier port keeps access. The request of each port is sampled on a shared clock. A port that enables, or moves onto the contested address, later than the other port is the late one. If both ports arrive on the same edge, a fixed priority settles the tie: port A wins and port B is flagged.

The block also qualifies each port's write strobe before the strobe reaches the array. In master mode the block decides busy itself, and a port that it flags busy cannot write. In slave mode a neighbouring arbiter makes the decision. The busy flags then come in as inputs, an asserted input blocks writes on its port, and the block holds its own busy outputs inactive. The mode input is expected to stay fixed while the block runs.

Top module: `port_clash_arbiter`

## Requirements
- R1: When either enable is low or the two addresses differ at a clock edge, both busy outputs are high (inactive) after that edge.
- R2: When a port becomes enabled on, or moves to, the address the other port already holds enabled, its busy output goes low after the edge that sampled its arrival, and the other port's busy stays high.
- R3: The two busy outputs are never low together.
- R4: When both ports arrive on the same address at the same edge, port B's busy goes low and port A's busy stays high.
- R5: While the match persists and neither port issues a new request, the busy decision does not change.
- R6: Busy is released (high) in the cycle after the addresses stop matching or either enable falls.
- R7: In master mode (mode input 0), a port's qualified write equals write AND enable AND (own busy output high). The busy inputs have no effect in this mode.
- R8: In slave mode (mode input 1), both busy outputs stay high, and a port's qualified write equals write AND enable AND (its busy input high).
- R9: While reset is held, both busy outputs are high. The first enabled request after reset counts as a new arrival.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for both ports |
| rst | input | 1 | Synchronous reset, active high |
| slave_mode | input | 1 | 0 = master (drives busy), 1 = slave (busy taken as input) |
| a_en | input | 1 | Port A enable, active high |
| a_addr | input | ADDR_W | Port A address |
| a_wr | input | 1 | Port A write strobe |
| b_en | input | 1 | Port B enable, active high |
| b_addr | input | ADDR_W | Port B address |
| b_wr | input | 1 | Port B write strobe |
| a_busy_in_n | input | 1 | Port A busy from the master arbiter (slave mode), active low |
| b_busy_in_n | input | 1 | Port B busy from the master arbiter (slave mode), active low |
| a_busy_n | output | 1 | Port A busy driven in master mode, active low |
| b_busy_n | output | 1 | Port B busy driven in master mode, active low |
| a_wr_q | output | 1 | Port A write to the array, after busy qualification |
| b_wr_q | output | 1 | Port B write to the array, after busy qualification |

## Verification
The bench builds the arbiter with ADDR_W set to 3. With only eight addresses, random traffic often lands both ports on one address, so collisions, same-edge ties, re-arrivals and releases all occur many times in a short run. Directed sequences cover the late-arrival cases for each port, the tie and the release. They also drive the busy inputs low in master mode to show those inputs have no effect. Random phases in both modes are then checked each cycle against a reference model in the bench.

// File: rtl/pca_pkg.sv
package pca_pkg;

    localparam int PCA_ADDR_W = 12;
    localparam int PCA_NPORT  = 2;

    typedef enum logic [1:0] {
        LOSER_NONE = 2'd0,
        LOSER_A    = 2'd1,
        LOSER_B    = 2'd2
    } loser_e;

    typedef struct packed {
        logic match;
        logic a_fresh;
        logic b_fresh;
    } clash_t;

    // Decide who loses for the next cycle. A fresh B loses ties (A has priority).
    function automatic loser_e pick_loser(clash_t c, loser_e held);
        loser_e r;
        if (!c.match)            r = LOSER_NONE;
        else if (c.b_fresh)      r = LOSER_B;
        else if (c.a_fresh)      r = LOSER_A;
        else if (held == LOSER_NONE) r = LOSER_B;
        else                     r = held;
        return r;
    endfunction

endpackage

// File: rtl/pca_arrival.sv
module pca_arrival #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [AW-1:0] addr,
    output logic          fresh
);
    logic          prev_en;
    logic [AW-1:0] prev_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_en   <= 1'b0;
            prev_addr <= '0;
        end else begin
            prev_en   <= en;
            prev_addr <= addr;
        end
    end

    assign fresh = en && !(prev_en && (prev_addr == addr));

    // A request that is held steady is never seen as a new arrival.
    assert_steady_not_fresh_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && en && $past(en) && $stable(addr)) |-> !fresh);

endmodule

// File: rtl/pca_decide.sv
module pca_decide
    import pca_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a_en,
    input  logic [AW-1:0] a_addr,
    input  logic          a_fresh,
    input  logic          b_en,
    input  logic [AW-1:0] b_addr,
    input  logic          b_fresh,
    output loser_e        loser
);
    clash_t c;
    loser_e loser_q;

    always_comb begin
        c.match   = a_en && b_en && (a_addr == b_addr);
        c.a_fresh = a_fresh;
        c.b_fresh = b_fresh;
    end

    always_ff @(posedge clk) begin
        if (rst) loser_q <= LOSER_NONE;
        else     loser_q <= pick_loser(c, loser_q);
    end

    assign loser = loser_q;

    assert_late_b_loses_R4: assert property (@(posedge clk) disable iff (rst)
        (c.match && b_fresh) |=> (loser_q == LOSER_B));

    assert_late_a_loses_R2: assert property (@(posedge clk) disable iff (rst)
        (c.match && a_fresh && !b_fresh) |=> (loser_q == LOSER_A));

    assert_release_R6: assert property (@(posedge clk) disable iff (rst)
        !c.match |=> (loser_q == LOSER_NONE));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (c.match && !a_fresh && !b_fresh && loser_q != LOSER_NONE) |=> $stable(loser_q));

endmodule

// File: rtl/pca_wr_gate.sv
module pca_wr_gate (
    input  logic slave_mode,
    input  logic busy_drv_n,
    input  logic busy_in_n,
    input  logic en,
    input  logic wr,
    output logic wr_q
);
    logic blocked;

    always_comb begin
        blocked = slave_mode ? !busy_in_n : !busy_drv_n;
        wr_q    = wr && en && !blocked;
    end

endmodule

// File: rtl/port_clash_arbiter.sv
module port_clash_arbiter
    import pca_pkg::*;
#(
    parameter int ADDR_W = PCA_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slave_mode,
    input  logic              a_en,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_wr,
    input  logic              b_en,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_wr,
    input  logic              a_busy_in_n,
    input  logic              b_busy_in_n,
    output logic              a_busy_n,
    output logic              b_busy_n,
    output logic              a_wr_q,
    output logic              b_wr_q
);
    localparam int NP = PCA_NPORT;

    logic [NP-1:0]             en_v, wr_v, bin_v, fresh_v, drv_v, wq_v;
    logic [NP-1:0][ADDR_W-1:0] addr_v;
    loser_e                    loser;

    assign en_v   = {b_en, a_en};
    assign wr_v   = {b_wr, a_wr};
    assign bin_v  = {b_busy_in_n, a_busy_in_n};
    assign addr_v = {b_addr, a_addr};

    generate
        for (genvar p = 0; p < NP; p++) begin : g_port
            pca_arrival #(.AW(ADDR_W)) u_arr (
                .clk   (clk),
                .rst   (rst),
                .en    (en_v[p]),
                .addr  (addr_v[p]),
                .fresh (fresh_v[p])
            );

            pca_wr_gate u_gate (
                .slave_mode (slave_mode),
                .busy_drv_n (drv_v[p]),
                .busy_in_n  (bin_v[p]),
                .en         (en_v[p]),
                .wr         (wr_v[p]),
                .wr_q       (wq_v[p])
            );
        end
    endgenerate

    pca_decide #(.AW(ADDR_W)) u_decide (
        .clk     (clk),
        .rst     (rst),
        .a_en    (a_en),
        .a_addr  (a_addr),
        .a_fresh (fresh_v[0]),
        .b_en    (b_en),
        .b_addr  (b_addr),
        .b_fresh (fresh_v[1]),
        .loser   (loser)
    );

    assign drv_v[0] = (loser != LOSER_A);
    assign drv_v[1] = (loser != LOSER_B);

    assign a_busy_n = slave_mode | drv_v[0];
    assign b_busy_n = slave_mode | drv_v[1];
    assign a_wr_q   = wq_v[0];
    assign b_wr_q   = wq_v[1];

    assert_single_loser_R3: assert property (@(posedge clk) disable iff (rst)
        (a_busy_n || b_busy_n));

    assert_idle_no_busy_R1: assert property (@(posedge clk) disable iff (rst)
        !(a_en && b_en && a_addr == b_addr) |=> (a_busy_n && b_busy_n));

    assert_master_lock_a_R7: assert property (@(posedge clk) disable iff (rst)
        (!slave_mode && !a_busy_n) |-> !a_wr_q);

    assert_master_lock_b_R7: assert property (@(posedge clk) disable iff (rst)
        (!slave_mode && !b_busy_n) |-> !b_wr_q);

    assert_slave_lock_R8: assert property (@(posedge clk) disable iff (rst)
        slave_mode |-> ((a_busy_in_n || !a_wr_q) && (b_busy_in_n || !b_wr_q)));

endmodule

// File: tb/port_clash_arbiter_tb.sv
module port_clash_arbiter_tb;
    localparam int AW = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, slave_mode, a_en, b_en, a_wr, b_wr, a_bin, b_bin;
    logic [AW-1:0] a_addr, b_addr;
    logic a_busy_n, b_busy_n, a_wr_q, b_wr_q;

    int n_total = 0;
    int n_fail  = 0;

    logic          m_pe [2];
    logic [AW-1:0] m_pa [2];
    int            m_loser;

    port_clash_arbiter #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .slave_mode(slave_mode),
        .a_en(a_en), .a_addr(a_addr), .a_wr(a_wr),
        .b_en(b_en), .b_addr(b_addr), .b_wr(b_wr),
        .a_busy_in_n(a_bin), .b_busy_in_n(b_bin),
        .a_busy_n(a_busy_n), .b_busy_n(b_busy_n),
        .a_wr_q(a_wr_q), .b_wr_q(b_wr_q)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_wr(input logic w, input logic e, input int port);
        logic blk;
        if (slave_mode) blk = (port == 0) ? !a_bin : !b_bin;
        else            blk = (m_loser == port + 1);
        return w && e && !blk;
    endfunction

    task automatic model_edge();
        logic match, af, bf;
        match = a_en && b_en && (a_addr == b_addr);
        af = a_en && !(m_pe[0] && m_pa[0] == a_addr);
        bf = b_en && !(m_pe[1] && m_pa[1] == b_addr);
        if (!match)          m_loser = 0;
        else if (bf)         m_loser = 2;
        else if (af)         m_loser = 1;
        else if (m_loser == 0) m_loser = 2;
        m_pe[0] = a_en; m_pa[0] = a_addr;
        m_pe[1] = b_en; m_pa[1] = b_addr;
    endtask

    // Inputs already set after a negedge. Checks writes, steps one edge, checks busy.
    task automatic run_cycle(input string tag);
        string wtag;
        wtag = slave_mode ? "R8" : "R7";
        #1;
        chk({wtag, " a_wr_q"}, a_wr_q, exp_wr(a_wr, a_en, 0));
        chk({wtag, " b_wr_q"}, b_wr_q, exp_wr(b_wr, b_en, 1));
        @(posedge clk);
        #1;
        model_edge();
        chk({tag, " a_busy_n"}, a_busy_n, slave_mode ? 1'b1 : (m_loser != 1));
        chk({tag, " b_busy_n"}, b_busy_n, slave_mode ? 1'b1 : (m_loser != 2));
        chk("R3 not both busy", a_busy_n | b_busy_n, 1'b1);
        @(negedge clk);
    endtask

    task automatic drive(input logic ae, input logic [AW-1:0] aa, input logic aw,
                         input logic be, input logic [AW-1:0] ba, input logic bw);
        a_en = ae; a_addr = aa; a_wr = aw;
        b_en = be; b_addr = ba; b_wr = bw;
    endtask

    initial begin
        #150000;
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        rst = 1'b1; slave_mode = 1'b0; a_bin = 1'b1; b_bin = 1'b1;
        drive(1'b1, 3'd2, 1'b0, 1'b1, 3'd2, 1'b0);
        m_pe[0] = 1'b0; m_pe[1] = 1'b0; m_pa[0] = '0; m_pa[1] = '0; m_loser = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset a_busy_n", a_busy_n, 1'b1);
        chk("R9 reset b_busy_n", b_busy_n, 1'b1);
        rst = 1'b0;
        // R9: both held enabled on the same address through reset: a tie at the first edge
        run_cycle("R9/R4 first after reset");
        chk("R9 b flagged after reset", b_busy_n, 1'b0);

        drive(1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0);
        run_cycle("R1 idle");
        drive(1'b1, 3'd5, 1'b1, 1'b0, 3'd5, 1'b1);
        run_cycle("R1 only A");
        drive(1'b1, 3'd5, 1'b1, 1'b1, 3'd5, 1'b1);
        run_cycle("R2 B late");
        chk("R2 B busy low", b_busy_n, 1'b0);
        a_bin = 1'b0; b_bin = 1'b0;   // R7: ignored in master mode
        run_cycle("R5 hold");
        run_cycle("R5 hold");
        chk("R5 A keeps access", a_busy_n, 1'b1);
        a_bin = 1'b1; b_bin = 1'b1;
        drive(1'b1, 3'd5, 1'b1, 1'b1, 3'd6, 1'b1);
        run_cycle("R6 B moves away");
        chk("R6 released", b_busy_n, 1'b1);
        drive(1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0);
        run_cycle("R1 drop");
        drive(1'b1, 3'd3, 1'b1, 1'b1, 3'd3, 1'b1);
        run_cycle("R4 tie");
        chk("R4 B flagged", b_busy_n, 1'b0);
        chk("R4 A clear", a_busy_n, 1'b1);
        drive(1'b0, 3'd3, 1'b1, 1'b1, 3'd3, 1'b1);
        run_cycle("R6 A off");
        run_cycle("R1 only B");
        drive(1'b1, 3'd3, 1'b1, 1'b1, 3'd3, 1'b1);
        run_cycle("R2 A late");
        chk("R2 A busy low", a_busy_n, 1'b0);
        run_cycle("R5 hold A");

        for (int i = 0; i < 800; i++) begin
            if ($urandom % 4 != 0) a_en = 1'b1; else a_en = 1'b0;
            if ($urandom % 4 != 0) b_en = 1'b1; else b_en = 1'b0;
            if ($urandom % 2 == 0) a_addr = AW'($urandom);
            if ($urandom % 2 == 0) b_addr = AW'($urandom);
            a_wr = 1'($urandom); b_wr = 1'($urandom);
            a_bin = 1'($urandom); b_bin = 1'($urandom);
            run_cycle("R1/R2/R4/R5/R6 random");
        end

        slave_mode = 1'b1;
        for (int i = 0; i < 400; i++) begin
            a_en = 1'($urandom); b_en = 1'($urandom);
            a_addr = AW'($urandom); b_addr = AW'($urandom);
            a_wr = 1'($urandom); b_wr = 1'($urandom);
            a_bin = 1'($urandom); b_bin = 1'($urandom);
            run_cycle("R8 slave outputs");
        end

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule